// File: doc/BRIEF.md
# Masked Set/Clear General-Purpose Output Port

A memory-mapped bank of general-purpose pins. Each pin has an output latch bit and a direction bit. Software can change pins in three ways. It can write ones to a set register or to a clear register, and each of these changes only the bits written as one. It can also write the whole pin value directly, and a mask register keeps selected bits from being changed. With the set and clear registers, one store changes a single pin and no load is needed first. With a direct pin write, some pins go high and others go low in the same clock edge.

The register bus has a word address, write data, a write enable, byte strobes and a combinational read-data output. Every write takes effect in one clock, with no wait states. Pad inputs pass through a two-flop synchroniser before they reach the read path. The latch drives the pad output vector and the direction register drives the pad output-enable vector.

Top module: `gpio_port`

## Requirements
- R1: A write to SET (address 0x04) makes 1 every latch bit whose data bit is 1 and whose byte strobe is high. All other latch bits keep their value.
- R2: A write to CLEAR (address 0x08) makes 0 every latch bit whose data bit is 1 and whose byte strobe is high. All other latch bits keep their value.
- R3: A write to PIN (address 0x00) changes only latch bits whose MASK bit is 0. Bits with MASK=1 keep their value.
- R4: In a single PIN write, every unmasked and strobed bit takes the written value. Some pins can therefore rise and others fall on the same clock edge.
- R5: Strobe bit i gates data bits 8i+7..8i. With a strobe of 0, every bit in that byte of the addressed register stays unchanged, whichever register is written.
- R6: MASK (0x0C) and DIR (0x10) take the written data bits under the byte strobes. A read of either returns its stored value.
- R7: A read of SET or CLEAR returns zero.
- R8: A read of PIN returns, for each bit, the latch bit when DIR=1 and the synchronised pad input when DIR=0. Bits with MASK=1 read as 0.
- R9: A change on pad_in shows in a PIN read after exactly two rising clock edges. After one edge the read still returns the old value.
- R10: While rst_n is low, the latch, DIR and MASK are cleared. pad_out and pad_oe are 0 and every readable register returns 0.
- R11: pad_out always equals the latch and pad_oe always equals DIR.
- R12: Each of the following leaves all state unchanged: a cycle without bus_we, a write to an unmapped word, or a write with nonzero bus_addr[1:0]. Reads in these last two cases return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register; must be word-aligned |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_be | input | 4 | Byte strobes for the write data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output levels (latch) |
| pad_oe | output | 32 | Pad output enables (direction) |

## Verification
The assertions assume the bus address and strobes are stable whenever bus_we is sampled. They also assume pad_in is taken as asynchronous only at the synchroniser's first stage. The bench drives every bus input and pad_in on the falling clock edge, so each write is a clean one-cycle pulse. It holds pad_in constant for two edges before it checks any PIN read that depends on it. The single-port bus never sees SET and CLEAR written in the same cycle, so nothing covers that case.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [2:0] {
        REG_PIN  = 3'd0,
        REG_SET  = 3'd1,
        REG_CLR  = 3'd2,
        REG_MASK = 3'd3,
        REG_DIR  = 3'd4,
        REG_NONE = 3'd7
    } reg_sel_e;

    // Word index decode; any nonzero low address bit selects nothing.
    function automatic reg_sel_e decode_addr(input logic [1:0] low,
                                             input logic [7:0] widx);
        reg_sel_e sel;
        if (low != 2'b00) begin
            sel = REG_NONE;
        end else begin
            case (widx)
                8'd0:    sel = REG_PIN;
                8'd1:    sel = REG_SET;
                8'd2:    sel = REG_CLR;
                8'd3:    sel = REG_MASK;
                8'd4:    sel = REG_DIR;
                default: sel = REG_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[LAST];

    generate
        if (STAGES >= 2) begin : g_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (stg_q[LAST] == $past(stg_q[LAST-1]))); // R9
        end
    endgenerate

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_sel_e     sel,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W/8-1:0] be,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] mask_o
);
    localparam int NB = W / 8;

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
        logic [W-1:0] mask;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] bmask;
    logic [W-1:0] hit;
    logic [W-1:0] pin_upd;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_bm
            assign bmask[g*8 +: 8] = {8{be[g]}};
        end
    endgenerate

    assign hit     = wdata & bmask;
    assign pin_upd = bmask & ~st_q.mask;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (sel)
                REG_PIN:  st_d.latch = (st_q.latch & ~pin_upd) | (wdata & pin_upd);
                REG_SET:  st_d.latch = st_q.latch | hit;
                REG_CLR:  st_d.latch = st_q.latch & ~hit;
                REG_MASK: st_d.mask  = (st_q.mask & ~bmask) | hit;
                REG_DIR:  st_d.dir   = (st_q.dir & ~bmask) | hit;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o = st_q.latch;
    assign dir_o   = st_q.dir;
    assign mask_o  = st_q.mask;

    AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_SET) |=> ((latch_o & $past(hit)) == $past(hit))); // R1
    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_SET) |=> (($past(latch_o) & ~latch_o) == '0)); // R1
    AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_CLR) |=> ((latch_o & $past(hit)) == '0)); // R2
    AST_CLR_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_CLR) |=> ((~$past(latch_o) & latch_o) == '0)); // R2
    AST_MASK_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_PIN) |=> (((latch_o ^ $past(latch_o)) & $past(mask_o)) == '0)); // R3
    AST_STROBE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((((latch_o ^ $past(latch_o)) | (dir_o ^ $past(dir_o)) |
                  (mask_o ^ $past(mask_o))) & ~$past(bmask)) == '0)); // R5
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == REG_MASK) |=> $stable(mask_o)); // R6
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == REG_DIR) |=> $stable(dir_o)); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || sel == REG_NONE) |=> ($stable(latch_o) && $stable(dir_o) && $stable(mask_o))); // R12

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  reg_sel_e     sel,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pad_sync,
    output logic [W-1:0] rdata
);
    logic [W-1:0] pin_view;

    assign pin_view = ((dir & latch) | (~dir & pad_sync)) & ~mask;

    always_comb begin
        case (sel)
            REG_PIN:  rdata = pin_view;
            REG_MASK: rdata = mask;
            REG_DIR:  rdata = dir;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W           = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W/8-1:0]    bus_be,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    reg_sel_e     sel;
    logic [W-1:0] latch_w, dir_w, mask_w, pad_sync_w;

    assign sel = decode_addr(bus_addr[1:0], 8'(bus_addr[ADDR_W-1:2]));

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pad_sync_w)
    );

    gpio_regfile #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .latch_o (latch_w),
        .dir_o   (dir_w),
        .mask_o  (mask_w)
    );

    gpio_rdmux #(.W(W)) u_rd (
        .sel      (sel),
        .latch    (latch_w),
        .dir      (dir_w),
        .mask     (mask_w),
        .pad_sync (pad_sync_w),
        .rdata    (bus_rdata)
    );

    assign pad_out = latch_w;
    assign pad_oe  = dir_w;

    AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_SET || sel == REG_CLR) |-> (bus_rdata == '0)); // R7
    AST_PIN_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_PIN) |-> ((bus_rdata & mask_w) == '0)); // R8
    AST_PIN_OUT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_PIN) |-> ((bus_rdata & dir_w) == (pad_out & pad_oe & ~mask_w))); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_NONE) |-> (bus_rdata == '0)); // R12

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int CLK_NS   = 10;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] m_latch = '0, m_dir = '0, m_mask = '0, m_pad = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_NS/2) clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            n_fail++;
            $display("FAIL watchdog all-R act=timeout exp=finish");
            summary();
            $finish;
        end
    end

    task automatic rnd(output logic [31:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic logic [31:0] pin_exp();
        return ((m_dir & m_latch) | (~m_dir & m_pad)) & ~m_mask;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] bm, upd;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        bm = bmask(be);
        case (a)
            5'h00: begin upd = bm & ~m_mask; m_latch = (m_latch & ~upd) | (d & upd); end
            5'h04: m_latch = m_latch | (d & bm);
            5'h08: m_latch = m_latch & ~(d & bm);
            5'h0C: m_mask = (m_mask & ~bm) | (d & bm);
            5'h10: m_dir = (m_dir & ~bm) | (d & bm);
            default: ;
        endcase
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk_pads(input string req);
        chk({req, " R11 pad_out"}, pad_out, m_latch);
        chk({req, " R11 pad_oe"}, pad_oe, m_dir);
    endtask

    initial begin
        logic [31:0] v, d;
        logic [4:0] a;
        string tag;
        repeat (3) @(negedge clk);
        // R10: reset values observed while held in reset
        chk("R10 pad_out in reset", pad_out, 32'h0);
        chk("R10 pad_oe in reset", pad_oe, 32'h0);
        rd(5'h00, v); chk("R10 PIN in reset", v, 32'h0);
        rd(5'h0C, v); chk("R10 MASK in reset", v, 32'h0);
        rd(5'h10, v); chk("R10 DIR in reset", v, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R9: synchroniser depth
        @(negedge clk); pad_in = 32'hC3A5_5A3C;
        @(negedge clk); rd(5'h00, v); chk("R9 one edge old", v, 32'h0);
        @(negedge clk); rd(5'h00, v); chk("R9 two edges new", v, 32'hC3A5_5A3C);
        m_pad = 32'hC3A5_5A3C;

        // R4: simultaneous rise and fall in one PIN write
        wr(5'h10, 32'hFFFF_FFFF, 4'hF);
        wr(5'h00, 32'hF0F0_F0F0, 4'hF);
        wr(5'h00, 32'h0FF0_0FF0, 4'hF);
        chk("R4 mixed pin write", pad_out, 32'h0FF0_0FF0);
        // R3: masked upper half kept
        wr(5'h0C, 32'hFFFF_0000, 4'hF);
        wr(5'h00, 32'hAAAA_AAAA, 4'hF);
        chk("R3 masked half kept", pad_out, 32'h0FF0_AAAA);
        rd(5'h00, v); chk("R8 masked bits read zero", v, 32'h0000_AAAA);
        // R1/R2 single pin store
        wr(5'h04, 32'h0000_0001, 4'hF);
        chk("R1 single set", pad_out, 32'h0FF0_AAAB);
        wr(5'h08, 32'h0000_0002, 4'hF);
        chk("R2 single clear", pad_out, 32'h0FF0_AAA9);
        wr(5'h0C, 32'h0, 4'hF);

        // R5/R1/R2/R3/R6 sweep over every strobe pattern and register
        for (int be = 0; be < 16; be++) begin
            for (int k = 0; k < 10; k++) begin
                rnd(d);
                case (k % 5)
                    0: begin a = 5'h04; tag = "R1 R5 set"; end
                    1: begin a = 5'h08; tag = "R2 R5 clear"; end
                    2: begin a = 5'h00; tag = "R3 R4 R5 pin"; end
                    3: begin a = 5'h0C; tag = "R6 R5 mask"; end
                    default: begin a = 5'h10; tag = "R6 R5 dir"; end
                endcase
                wr(a, d, 4'(be));
                chk_pads(tag);
                rd(5'h00, v); chk("R8 pin read", v, pin_exp());
                rd(5'h0C, v); chk("R6 mask read", v, m_mask);
                rd(5'h10, v); chk("R6 dir read", v, m_dir);
                rd(5'h04, v); chk("R7 set reads zero", v, 32'h0);
                rd(5'h08, v); chk("R7 clear reads zero", v, 32'h0);
            end
        end

        // R8: pad input patterns under varied direction/mask
        for (int k = 0; k < 8; k++) begin
            rnd(d); wr(5'h10, d, 4'hF);
            rnd(d); wr(5'h0C, d & 32'h0F0F_0F0F, 4'hF);
            rnd(d); @(negedge clk); pad_in = d;
            @(negedge clk); @(negedge clk); m_pad = d;
            rd(5'h00, v); chk("R8 R9 pin mux", v, pin_exp());
        end

        // R12: idle, unmapped, unaligned
        wr(5'h0C, 32'h0, 4'hF);
        repeat (4) @(negedge clk);
        chk_pads("R12 idle");
        wr(5'h14, 32'hFFFF_FFFF, 4'hF);
        chk_pads("R12 unmapped write");
        wr(5'h05, 32'hFFFF_FFFF, 4'hF);
        chk_pads("R12 unaligned set");
        wr(5'h01, 32'h0, 4'hF);
        chk_pads("R12 unaligned pin");
        rd(5'h14, v); chk("R12 unmapped read", v, 32'h0);
        rd(5'h1C, v); chk("R12 unmapped read hi", v, 32'h0);
        rd(5'h0E, v); chk("R12 unaligned read", v, 32'h0);
        rd(5'h0C, v); chk("R12 mask intact", v, m_mask);
        rd(5'h10, v); chk("R12 dir intact", v, m_dir);

        done = 1;
        summary();
        $finish;
    end

endmodule